// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves a data word between two bidirectional buses, A and B, either straight through or from a holding register. Each side owns a storage register with its own capture strobe. The strobe is sampled on the common system clock, and the register takes whatever value the bus pins carry in that cycle. A per-direction selector decides whether an enabled bus is driven with the live word from the opposite bus or with the word held in the opposite side's register.

Each bus appears at the boundary as an input vector (the resolved bus value), an output vector and an output enable. The surrounding fabric or testbench merges these into the shared wire. A build-time parameter picks the control style. In single-enable style, one active-low enable plus a direction bit allow at most one bus to be driven. In dual-enable style, two independent enables allow both buses to be driven at once. A second parameter makes every transfer, live or stored, complement the data.

Top module: `dual_bus_xcvr`

## Requirements
- R1: A low `rst_n` at a clock edge clears both storage registers to zero. Reading a register afterwards through the stored path gives all zeros, or all ones in an inverting build.
- R2: When `cap_a` is high at a rising clock edge, the A register loads the value on `a_in`, whatever the selects and enables are. When `cap_a` is low, the A register holds its value.
- R3: When `cap_b` is high at a rising clock edge, the B register loads the value on `b_in`, whatever the selects and enables are. When `cap_b` is low, the B register holds its value.
- R4: A select at 0 drives the enabled bus with the live word from the opposite bus's input in the same cycle, with no register in between (`sel_b_src` sets what drives B, `sel_a_src` sets what drives A).
- R5: A select at 1 drives the enabled bus with the opposite side's register (`b_out` from the A register, `a_out` from the B register). The output then stays steady while that register and the select are unchanged.
- R6: In single-enable style (`CTRL_STYLE` = `CTRL_SINGLE`), `ctl_en_n`=1 disables both buses. With `ctl_en_n`=0, `ctl_dir`=0 enables only A and `ctl_dir`=1 enables only B. The two enables are never high together.
- R7: In dual-enable style (`CTRL_STYLE` = `CTRL_DUAL`), `a_oe` is the inverse of `ctl_en_n` and `b_oe` equals `ctl_dir`, each independent of the other. With `ctl_en_n`=0 and `ctl_dir`=1, both buses are driven, and with both selects at 1 the buses exchange their stored words.
- R8: A register captures its own bus even while the block drives that bus. For example, with B driven by live A data and both strobes high, both registers end up holding the A word.
- R9: With `INVERT`=1, every driven word (live or stored) is the bitwise complement of its source. With `INVERT`=0, it is passed unchanged. Registers always store the uninverted bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all storage updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of both registers |
| a_in | input | WIDTH | Resolved value present on bus A |
| a_out | output | WIDTH | Word the block drives onto bus A |
| a_oe | output | 1 | High while the block drives bus A |
| b_in | input | WIDTH | Resolved value present on bus B |
| b_out | output | WIDTH | Word the block drives onto bus B |
| b_oe | output | 1 | High while the block drives bus B |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |
| sel_a_src | input | 1 | Source for bus A: 0 live B, 1 B register |
| sel_b_src | input | 1 | Source for bus B: 0 live A, 1 A register |
| ctl_en_n | input | 1 | Single style: active-low global enable; dual style: active-low A enable |
| ctl_dir | input | 1 | Single style: direction (1 = drive B); dual style: active-high B enable |

## Verification
The bench aims at captures made while the block itself drives the captured bus. A design that sampled only external data, or sampled the opposite bus, would leave the wrong word in the register and fail the later read-back. It runs both control styles side by side, so a decoder that let single style drive both buses, or tied the dual enables together, produces a wrong enable pair on some truth-table row. It also exercises the stored-word exchange in the inverting build, where a design that inverted on capture instead of on output, or inverted only the live path, returns a double-complemented or uncomplemented word.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the registered bus transceiver.
// Assumes: nothing beyond IEEE 1800-2017.
package xcvr_pkg;
    // Control style chosen at build time.
    typedef enum logic {
        CTRL_SINGLE = 1'b0,  // one active-low enable plus a direction bit
        CTRL_DUAL   = 1'b1   // two independent per-bus enables
    } ctrl_style_e;

    localparam int unsigned DEFAULT_WIDTH = 8;
endpackage

// File: rtl/xcvr_store.sv
// Holding register for one side of the transceiver.
// Loads its bus value whenever the capture strobe is high at a clock edge.
// Assumes: the strobe is already synchronous to clk; reset is synchronous, active low.
module xcvr_store #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture or hold the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> q == '0); // R1
    AST_CAPTURE_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> q == $past(d)); // R2 R3
    AST_HOLD_WITHOUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(q)); // R2 R3
endmodule

// File: rtl/xcvr_oe_decode.sv
// Turns the two control inputs into per-bus output enables.
// The meaning of the inputs depends on CTRL_STYLE.
// Assumes: purely combinational; no state.
module xcvr_oe_decode
    import xcvr_pkg::*;
#(
    parameter ctrl_style_e CTRL_STYLE = CTRL_SINGLE
) (
    input  logic ctl_en_n,
    input  logic ctl_dir,
    output logic a_oe,
    output logic b_oe
);
    generate
        if (CTRL_STYLE == CTRL_SINGLE) begin : g_single
            // One enable gates both directions; direction picks the bus.
            always_comb begin
                a_oe = !ctl_en_n && !ctl_dir;
                b_oe = !ctl_en_n &&  ctl_dir;
            end
        end else begin : g_dual
            // Each bus has its own enable; both may be on together.
            always_comb begin
                a_oe = !ctl_en_n;
                b_oe = ctl_dir;
            end
        end
    endgenerate
endmodule

// File: rtl/xcvr_path.sv
// Data source selector for one direction: live opposite-bus word or stored word,
// with an optional complement applied on the way out.
// Assumes: purely combinational.
module xcvr_path #(
    parameter int unsigned WIDTH  = 8,
    parameter bit          INVERT = 1'b0
) (
    input  logic             sel_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] picked;

    // Choose between the live and the stored word.
    always_comb picked = sel_stored ? stored : live;

    generate
        if (INVERT) begin : g_inv
            // Inverting build: complement every transfer.
            always_comb y = ~picked;
        end else begin : g_pass
            // Non-inverting build: pass through.
            always_comb y = picked;
        end
    endgenerate
endmodule

// File: rtl/dual_bus_xcvr.sv
// Registered bidirectional transceiver between buses A and B.
// Each bus is split into resolved input, driven output and enable; the outputs
// are combinational in the selects, enables, live inputs and stored words.
// Assumes: the environment never enables both buses with both selects live
// (that would be a combinational loop through the external wires).
module dual_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH      = DEFAULT_WIDTH,
    parameter ctrl_style_e CTRL_STYLE = CTRL_SINGLE,
    parameter bit          INVERT     = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic             sel_a_src,
    input  logic             sel_b_src,
    input  logic             ctl_en_n,
    input  logic             ctl_dir
);
    logic [WIDTH-1:0] reg_a;
    logic [WIDTH-1:0] reg_b;

    // A-side register: samples bus A pins, including when the block drives A.
    xcvr_store #(.WIDTH(WIDTH)) u_store_a (
        .clk(clk), .rst_n(rst_n), .cap(cap_a), .d(a_in), .q(reg_a)
    );

    // B-side register: samples bus B pins, including when the block drives B.
    xcvr_store #(.WIDTH(WIDTH)) u_store_b (
        .clk(clk), .rst_n(rst_n), .cap(cap_b), .d(b_in), .q(reg_b)
    );

    // Enable decode for the chosen control style.
    xcvr_oe_decode #(.CTRL_STYLE(CTRL_STYLE)) u_oe (
        .ctl_en_n(ctl_en_n), .ctl_dir(ctl_dir), .a_oe(a_oe), .b_oe(b_oe)
    );

    // Word sent toward B: live A or stored A.
    xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
        .sel_stored(sel_b_src), .live(a_in), .stored(reg_a), .y(b_out)
    );

    // Word sent toward A: live B or stored B.
    xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
        .sel_stored(sel_a_src), .live(b_in), .stored(reg_b), .y(a_out)
    );

    AST_STORED_B_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b_src && $stable(sel_b_src) && $stable(reg_a)) |-> $stable(b_out)); // R5
    AST_STORED_A_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_src && $stable(sel_a_src) && $stable(reg_b)) |-> $stable(a_out)); // R5

    generate
        if (CTRL_STYLE == CTRL_SINGLE) begin : g_single_chk
            AST_SINGLE_ONE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({a_oe, b_oe})); // R6
            AST_SINGLE_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
                ctl_en_n |-> (!a_oe && !b_oe)); // R6
        end else begin : g_dual_chk
            AST_DUAL_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctl_en_n && ctl_dir) |-> (a_oe && b_oe)); // R7
            AST_DUAL_A_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                ctl_en_n |-> !a_oe); // R7
        end
    endgenerate
endmodule

// File: tb/tb_dual_bus_xcvr.sv
// Bench: a single-style non-inverting instance and a dual-style inverting
// instance share stimulus; a bench model predicts enables, data and registers.
module tb_dual_bus_xcvr;
    import xcvr_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic ctl_en_n = 1'b1, ctl_dir = 1'b0, sel_a = 1'b0, sel_b = 1'b0;
    logic cap_a = 1'b0, cap_b = 1'b0;
    logic [7:0] ext_a = '0, ext_b = '0;

    logic [7:0] s_a_in = '0, s_b_in = '0, s_a_out, s_b_out;
    logic       s_a_oe, s_b_oe;
    logic [7:0] d_a_in = '0, d_b_in = '0, d_a_out, d_b_out;
    logic       d_a_oe, d_b_oe;

    int checks = 0;
    int errors = 0;

    dual_bus_xcvr #(.WIDTH(8), .CTRL_STYLE(CTRL_SINGLE), .INVERT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(s_a_in), .a_out(s_a_out), .a_oe(s_a_oe),
        .b_in(s_b_in), .b_out(s_b_out), .b_oe(s_b_oe),
        .cap_a(cap_a), .cap_b(cap_b), .sel_a_src(sel_a), .sel_b_src(sel_b),
        .ctl_en_n(ctl_en_n), .ctl_dir(ctl_dir)
    );

    dual_bus_xcvr #(.WIDTH(8), .CTRL_STYLE(CTRL_DUAL), .INVERT(1'b1)) dut_dual (
        .clk(clk), .rst_n(rst_n),
        .a_in(d_a_in), .a_out(d_a_out), .a_oe(d_a_oe),
        .b_in(d_b_in), .b_out(d_b_out), .b_oe(d_b_oe),
        .cap_a(cap_a), .cap_b(cap_b), .sel_a_src(sel_a), .sel_b_src(sel_b),
        .ctl_en_n(ctl_en_n), .ctl_dir(ctl_dir)
    );

    // Vector: {ctl_en_n, ctl_dir, sel_a, sel_b, cap_a, cap_b, ext_a, ext_b}.
    // No row enables both buses with both selects live.
    localparam int NVEC = 16;
    localparam logic [21:0] VECS [NVEC] = '{
        {6'b100011, 8'h3C, 8'hC3},
        {6'b111100, 8'hFF, 8'h00},
        {6'b000000, 8'h11, 8'h96},
        {6'b001000, 8'h22, 8'h77},
        {6'b010100, 8'h5A, 8'h0F},
        {6'b011100, 8'h44, 8'h88},
        {6'b011011, 8'hA5, 8'h66},
        {6'b001100, 8'h00, 8'h00},
        {6'b011100, 8'h12, 8'h34},
        {6'b110010, 8'hE7, 8'h18},
        {6'b001001, 8'h99, 8'h42},
        {6'b010110, 8'h3C, 8'h81},
        {6'b011111, 8'h6E, 8'h9D},
        {6'b001100, 8'h01, 8'h02},
        {6'b101100, 8'h03, 8'h04},
        {6'b011100, 8'hFF, 8'hFF}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Resolve both buses of both instances from their enables and the external drivers.
    task automatic settle();
        for (int k = 0; k < 3; k++) begin
            #1;
            s_a_in = s_a_oe ? s_a_out : ext_a;
            s_b_in = s_b_oe ? s_b_out : ext_b;
            d_a_in = d_a_oe ? d_a_out : ext_a;
            d_b_in = d_b_oe ? d_b_out : ext_b;
        end
    endtask

    task automatic drive(input logic [21:0] v);
        {ctl_en_n, ctl_dir, sel_a, sel_b, cap_a, cap_b} = v[21:16];
        ext_a = v[15:8];
        ext_b = v[7:0];
        settle();
    endtask

    // Reference model of one instance from the requirements.
    task automatic model(input bit dual, input bit inv, input logic [21:0] v,
                         input logic [7:0] ra, input logic [7:0] rb,
                         output logic aoe, output logic boe,
                         output logic [7:0] aout, output logic [7:0] bout,
                         output logic [7:0] busa, output logic [7:0] busb);
        logic en_n, dir, sa, sb;
        logic [7:0] m;
        {en_n, dir, sa, sb} = v[21:18];
        m = inv ? 8'hFF : 8'h00;
        aoe = dual ? !en_n : (!en_n && !dir);
        boe = dual ? dir : (!en_n && dir);
        busa = v[15:8];
        busb = v[7:0];
        aout = '0;
        bout = '0;
        if (aoe && sa) begin aout = rb ^ m; busa = aout; end
        if (boe && sb) begin bout = ra ^ m; busb = bout; end
        if (aoe && !sa) begin aout = busb ^ m; busa = aout; end
        if (boe && !sb) begin bout = busa ^ m; busb = bout; end
    endtask

    logic [7:0] mra_s = '0, mrb_s = '0, mra_d = '0, mrb_d = '0;

    initial begin
        logic aoe, boe;
        logic [7:0] aout, bout, busa, busb;

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: registers start at zero (stored path, A enabled)
        drive({6'b001000, 8'hAA, 8'h55});
        #2;
        chk("R1 single stored A after reset", s_a_out, 8'h00);
        chk("R1 dual stored A after reset (inverted)", d_a_out, 8'hFF);

        // Table walk against the model (R4 R5 R6 R7 R9).
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #2;
            model(1'b0, 1'b0, VECS[i], mra_s, mrb_s, aoe, boe, aout, bout, busa, busb);
            chk($sformatf("R6 single enables row %0d", i), {6'b0, s_a_oe, s_b_oe}, {6'b0, aoe, boe});
            if (aoe) chk($sformatf("%s single A row %0d", VECS[i][19] ? "R5" : "R4", i), s_a_out, aout);
            if (boe) chk($sformatf("%s single B row %0d", VECS[i][18] ? "R5" : "R4", i), s_b_out, bout);
            if (VECS[i][17]) mra_s = busa;
            if (VECS[i][16]) mrb_s = busb;
            model(1'b1, 1'b1, VECS[i], mra_d, mrb_d, aoe, boe, aout, bout, busa, busb);
            chk($sformatf("R7 dual enables row %0d", i), {6'b0, d_a_oe, d_b_oe}, {6'b0, aoe, boe});
            if (aoe) chk($sformatf("R9 dual inverted A row %0d", i), d_a_out, aout);
            if (boe) chk($sformatf("R9 dual inverted B row %0d", i), d_b_out, bout);
            if (VECS[i][17]) mra_d = busa;
            if (VECS[i][16]) mrb_d = busb;
        end

        // R2: capture A while isolated, then hold with strobe low
        @(negedge clk); drive({6'b100010, 8'hC9, 8'h00});
        @(negedge clk); drive({6'b011100, 8'h00, 8'h00});
        #2;
        chk("R2 single A register read on B", s_b_out, 8'hC9);
        chk("R2 dual A register read on B (inverted)", d_b_out, 8'h36);
        @(negedge clk); drive({6'b011100, 8'h77, 8'h11});
        #2;
        chk("R2 A register held without strobe", s_b_out, 8'hC9);

        // R3: capture B while isolated, read via A
        @(negedge clk); drive({6'b100001, 8'h00, 8'h6B});
        @(negedge clk); drive({6'b001100, 8'h00, 8'h00});
        #2;
        chk("R3 single B register read on A", s_a_out, 8'h6B);
        chk("R3 dual B register read on A (inverted)", d_a_out, 8'h94);

        // R8: B driven with live A, both strobes: A word lands in both registers
        @(negedge clk); drive({6'b011011, 8'hD2, 8'h00});
        #2;
        chk("R8 single live A on B", s_b_out, 8'hD2);
        @(negedge clk); drive({6'b001100, 8'h00, 8'h00});
        #2;
        chk("R8 single B register holds A word", s_a_out, 8'hD2);
        @(negedge clk); drive({6'b011100, 8'h00, 8'h00});
        #2;
        chk("R8 single A register holds A word", s_b_out, 8'hD2);

        // R1: reset in mid-run clears stored words
        @(negedge clk); rst_n = 1'b0; drive({6'b001000, 8'h00, 8'h00});
        @(negedge clk); rst_n = 1'b1; settle();
        #2;
        chk("R1 single cleared by mid-run reset", s_a_out, 8'h00);
        chk("R1 dual cleared by mid-run reset", d_a_out, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(2_000_000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule